// File: doc/BRIEF.md
# Buffered Sawtooth PWM Generator with Dead-Time Insertion

This block produces edge-aligned pulse-width modulation on several channels from one shared time base. An up-counter starts at zero, counts one step per base-clock cycle while the run enable is high, and falls back to zero on the cycle after it equals the active period value. Each duty channel keeps an internal level that goes high when the counter leaves zero and goes low on the channel's duty match. That level drives a complementary output pair: a positive phase and a negative phase, kept apart by a programmable dead time.

Software never writes the active compare values directly. Period and duty values go into shadow registers. They are copied to the active registers only on the period-match cycle, and only while the matching transfer enable is set. There is one enable for the period and one shared by all duty channels. Retuning therefore never tears a running period. Single-cycle interrupt pulses mark each duty match and each period match. A polarity input inverts every output after dead-time insertion.

Top module: `sawpwm_dt`

## Requirements
- R1: While `run_en` is high the counter steps from 0 up to the active period P and then returns to 0, so `irq_prd` pulses high for one cycle once every P+1 cycles. The pulse appears one cycle after the counter equals P.
- R2: A shadow write (`prd_wr`, `duty_wr[i]`) changes no output behaviour until a period match takes place with the matching transfer enable set. The active value in force before the match stays in use.
- R3: On a period match the shadow period is copied to the active period only when `xfer_prd_en` is 1, and all shadow duties are copied only when `xfer_duty_en` is 1. With an enable at 0, the active value it governs is kept.
- R4: With `run_en` low the counter is held at 0, the channel levels are cleared, and all outputs become inactive one cycle later. After `run_en` rises, counting restarts from 0.
- R5: For an active duty D with 0 < D < P, the channel level is high exactly while the counter is in 1..D. It rises one cycle after the counter was 0 and falls one cycle after the counter equalled D.
- R6: An active duty of 0 keeps the positive phase inactive. An active duty of at least P keeps the level high across the whole period, so that after the first period the positive phase stays active and the negative phase stays inactive.
- R7: After every change of a channel's level, both outputs of that channel stay inactive for `dt_val`+1 cycles. The positive and negative phases are never active together.
- R8: `irq_duty[i]` pulses high for one cycle, one cycle after the counter equals the active duty of channel i while running.
- R9: With `pol_inv` = 1 every `out_pos` and `out_neg` bit is inverted, taking effect at once. With `pol_inv` = 0 the outputs are active-high.
- R10: During synchronous reset (`rst_n` low) and on the cycle after it, all counters, registers and interrupt pulses are zero and both phases are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Count enable; low holds and clears the channels |
| prd_wr | input | 1 | Write strobe for the period shadow register |
| prd_wdata | input | CNT_W | Period shadow write data |
| duty_wr | input | N_CH | Per-channel write strobes for the duty shadow registers |
| duty_wdata | input | CNT_W | Duty shadow write data shared by all channels |
| dt_val | input | DT_W | Dead-time value; the gap is dt_val+1 cycles |
| xfer_prd_en | input | 1 | Allows the period shadow-to-active copy |
| xfer_duty_en | input | 1 | Allows the duty shadow-to-active copies |
| pol_inv | input | 1 | Inverts both phases of every channel |
| out_pos | output | N_CH | Positive-phase outputs |
| out_neg | output | N_CH | Negative-phase outputs |
| irq_duty | output | N_CH | Duty-match interrupt pulses |
| irq_prd | output | 1 | Period-match interrupt pulse |

## Verification
The hardest cases to reach from the ports are period boundaries where a transfer enable is off while the shadow holds a different value, and pulses shorter than the dead time. In the second case a channel's positive phase must stay inactive even though its level toggles every period. The stimulus first loads shadows with each enable cleared in turn and runs across several boundaries. It then sets a dead time longer than the narrowest duty pulse. A behavioural model in the bench tracks the counter, the shadow and active values, and a history of each channel level. On every cycle it derives the expected outputs from that state and compares them with the design.

// File: rtl/sawpwm_pkg.sv
// Package: shared types for the sawtooth PWM block.
// Assumes: used by all sawpwm modules; holds no logic.
package sawpwm_pkg;

    // Complementary output pair of one channel, before polarity.
    typedef struct packed {
        logic pos;
        logic neg;
    } pwm_pair_t;

endpackage

// File: rtl/sawpwm_timebase.sv
// Module: sawpwm_timebase
// Free-running up-counter that wraps at the active period, with a
// double-buffered period register and a registered period-match pulse.
// Assumes: shadow-to-active copy only on the match cycle; run_en low
// holds the counter at zero.
module sawpwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             prd_wr,
    input  logic [CNT_W-1:0] prd_wdata,
    input  logic             xfer_prd_en,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_prd,
    output logic             prd_match,
    output logic             irq_prd
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] shd_prd_q;
    logic [CNT_W-1:0] act_prd_q;
    logic             irq_q;

    assign prd_match = run_en && (cnt_q == act_prd_q);
    assign cnt       = cnt_q;
    assign act_prd   = act_prd_q;
    assign irq_prd   = irq_q;

    // Sawtooth counter: clear when idle or on period match, else step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_en || prd_match) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Period shadow register, written by software at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_prd_q <= '0;
        end else if (prd_wr) begin
            shd_prd_q <= prd_wdata;
        end
    end

    // Active period: loaded from the shadow only on an enabled match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_prd_q <= '0;
        end else if (prd_match && xfer_prd_en) begin
            act_prd_q <= shd_prd_q;
        end
    end

    // Period-match interrupt pulse, one cycle after the match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= prd_match;
        end
    end

    // R1: the counter never runs past the active period.
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= act_prd_q);

    // R2: the active period only moves on a period match.
    p_prd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !prd_match |=> $stable(act_prd_q));

    // R4: idle run enable leaves the counter at zero.
    p_idle_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (cnt_q == '0));

endmodule

// File: rtl/sawpwm_duty_ch.sv
// Module: sawpwm_duty_ch
// One duty channel: buffered duty compare, PWM level flip-flop and a
// registered duty-match pulse.
// Assumes: cnt, act_prd and prd_match come from the shared time base;
// the level is set when the counter leaves zero and cleared on match.
module sawpwm_duty_ch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] act_prd,
    input  logic             prd_match,
    input  logic             xfer_duty_en,
    input  logic             duty_wr,
    input  logic [CNT_W-1:0] duty_wdata,
    output logic             level,
    output logic             irq_match
);

    logic [CNT_W-1:0] shd_duty_q;
    logic [CNT_W-1:0] act_duty_q;
    logic             lvl_q;
    logic             irq_q;
    logic             duty_hit;
    logic             clr_hit;

    assign duty_hit  = (cnt == act_duty_q);
    assign clr_hit   = duty_hit && (act_duty_q < act_prd);
    assign level     = lvl_q;
    assign irq_match = irq_q;

    // Duty shadow register, written by software at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_duty_q <= '0;
        end else if (duty_wr) begin
            shd_duty_q <= duty_wdata;
        end
    end

    // Active duty: loaded from the shadow only on an enabled period match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_duty_q <= '0;
        end else if (prd_match && xfer_duty_en) begin
            act_duty_q <= shd_duty_q;
        end
    end

    // Level flip-flop: set leaving zero, cleared on a duty match below period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            lvl_q <= 1'b0;
        end else if (cnt == '0) begin
            lvl_q <= (act_duty_q != '0);
        end else if (clr_hit) begin
            lvl_q <= 1'b0;
        end
    end

    // Duty-match interrupt pulse, one cycle after the match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= run_en && duty_hit;
        end
    end

    // R3: the active duty only moves on a period match.
    p_duty_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !prd_match |=> $stable(act_duty_q));

    // R6: a zero duty keeps the level low once the counter has left zero.
    p_zero_duty_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && (cnt != '0) && (act_duty_q == '0)) |-> !lvl_q);

endmodule

// File: rtl/sawpwm_deadtime.sv
// Module: sawpwm_deadtime
// Dead-time insertion for one channel: every level change reloads a
// down-counter, and both phases stay inactive until it has expired.
// Assumes: level is a registered signal; dt_val may change only when idle
// for exact gap lengths.
module sawpwm_deadtime
    import sawpwm_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            level,
    input  logic [DT_W-1:0] dt_val,
    output pwm_pair_t       pair
);

    logic            lvl_last_q;
    logic [DT_W-1:0] dtc_q;
    logic            edge_now;
    logic            quiet;
    pwm_pair_t       pair_q;

    assign edge_now = (level != lvl_last_q);
    assign quiet    = !edge_now && (dtc_q == '0);
    assign pair     = pair_q;

    // Remember the previous level to detect its edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_last_q <= 1'b0;
        end else begin
            lvl_last_q <= level;
        end
    end

    // Dead-time counter: reload on each level edge, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            dtc_q <= '0;
        end else if (edge_now) begin
            dtc_q <= dt_val;
        end else if (dtc_q != '0) begin
            dtc_q <= dtc_q - 1'b1;
        end
    end

    // Output pair: follow the level only once the gap has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            pair_q <= '0;
        end else begin
            pair_q.pos <= quiet && level;
            pair_q.neg <= quiet && !level;
        end
    end

    // R7: the two phases never overlap.
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pair_q.pos && pair_q.neg));

    // R7: a level edge forces both phases inactive on the next cycle.
    p_edge_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_now |=> (!pair_q.pos && !pair_q.neg));

    // R4: dropping the run enable makes both phases inactive.
    p_idle_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!pair_q.pos && !pair_q.neg));

endmodule

// File: rtl/sawpwm_dt.sv
// Module: sawpwm_dt (top)
// Multi-channel edge-aligned PWM: one shared buffered time base, N_CH
// buffered duty channels, each with dead-time insertion and a polarity
// stage on its complementary outputs.
// Assumes: all inputs synchronous to clk; bus decoding done outside.
module sawpwm_dt
    import sawpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_CH  = 3,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             prd_wr,
    input  logic [CNT_W-1:0] prd_wdata,
    input  logic [N_CH-1:0]  duty_wr,
    input  logic [CNT_W-1:0] duty_wdata,
    input  logic [DT_W-1:0]  dt_val,
    input  logic             xfer_prd_en,
    input  logic             xfer_duty_en,
    input  logic             pol_inv,
    output logic [N_CH-1:0]  out_pos,
    output logic [N_CH-1:0]  out_neg,
    output logic [N_CH-1:0]  irq_duty,
    output logic             irq_prd
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] act_prd;
    logic             prd_match;

    sawpwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .prd_wr      (prd_wr),
        .prd_wdata   (prd_wdata),
        .xfer_prd_en (xfer_prd_en),
        .cnt         (cnt),
        .act_prd     (act_prd),
        .prd_match   (prd_match),
        .irq_prd     (irq_prd)
    );

    for (genvar gi = 0; gi < N_CH; gi++) begin : g_ch
        logic      level;
        pwm_pair_t pair;

        sawpwm_duty_ch #(.CNT_W(CNT_W)) u_duty (
            .clk          (clk),
            .rst_n        (rst_n),
            .run_en       (run_en),
            .cnt          (cnt),
            .act_prd      (act_prd),
            .prd_match    (prd_match),
            .xfer_duty_en (xfer_duty_en),
            .duty_wr      (duty_wr[gi]),
            .duty_wdata   (duty_wdata),
            .level        (level),
            .irq_match    (irq_duty[gi])
        );

        sawpwm_deadtime #(.DT_W(DT_W)) u_dt (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_en (run_en),
            .level  (level),
            .dt_val (dt_val),
            .pair   (pair)
        );

        // Polarity stage applied after dead-time insertion.
        assign out_pos[gi] = pair.pos ^ pol_inv;
        assign out_neg[gi] = pair.neg ^ pol_inv;
    end

endmodule

// File: tb/tb_sawpwm_dt.sv
`timescale 1ns/1ps
module tb_sawpwm_dt;

    localparam int CNT_W = 16;
    localparam int N_CH  = 3;
    localparam int DT_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             run_en;
    logic             prd_wr;
    logic [CNT_W-1:0] prd_wdata;
    logic [N_CH-1:0]  duty_wr;
    logic [CNT_W-1:0] duty_wdata;
    logic [DT_W-1:0]  dt_val;
    logic             xfer_prd_en;
    logic             xfer_duty_en;
    logic             pol_inv;
    logic [N_CH-1:0]  out_pos;
    logic [N_CH-1:0]  out_neg;
    logic [N_CH-1:0]  irq_duty;
    logic             irq_prd;

    sawpwm_dt #(.CNT_W(CNT_W), .N_CH(N_CH), .DT_W(DT_W)) dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .prd_wr(prd_wr),
        .prd_wdata(prd_wdata), .duty_wr(duty_wr), .duty_wdata(duty_wdata),
        .dt_val(dt_val), .xfer_prd_en(xfer_prd_en), .xfer_duty_en(xfer_duty_en),
        .pol_inv(pol_inv), .out_pos(out_pos), .out_neg(out_neg),
        .irq_duty(irq_duty), .irq_prd(irq_prd)
    );

    always #10 clk = ~clk;   // 50 MHz

    int    n_vec  = 0;
    int    n_bad  = 0;
    bit    chk_on = 0;
    bit    done   = 0;
    string tag    = "R10 reset";

    // Behavioural reference state.
    int          m_cnt, m_prd, m_sprd;
    int          m_duty [N_CH];
    int          m_sduty[N_CH];
    bit          m_ff   [N_CH];
    logic [63:0] m_hist [N_CH];
    bit          m_pos  [N_CH];
    bit          m_neg  [N_CH];
    bit          m_irqd [N_CH];
    bit          m_irqp;

    bit          t_match;
    bit          t_ff;
    logic [63:0] t_win;
    logic [63:0] t_mask;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_prd = 0; m_sprd = 0; m_irqp = 0;
            for (int i = 0; i < N_CH; i++) begin
                m_duty[i] = 0; m_sduty[i] = 0; m_ff[i] = 0; m_hist[i] = '0;
                m_pos[i] = 0; m_neg[i] = 0; m_irqd[i] = 0;
            end
        end else begin
            t_match = run_en && (m_cnt == m_prd);
            t_mask  = (64'd1 << (int'(dt_val) + 2)) - 64'd1;
            for (int i = 0; i < N_CH; i++) begin
                m_irqd[i] = run_en && (m_cnt == m_duty[i]);
                if (!run_en)                                  t_ff = 0;
                else if (m_cnt == 0)                          t_ff = (m_duty[i] != 0);
                else if (m_cnt == m_duty[i] && m_duty[i] < m_prd) t_ff = 0;
                else                                          t_ff = m_ff[i];
                t_win    = {m_hist[i][62:0], m_ff[i]};
                m_pos[i] = run_en && ((t_win & t_mask) == t_mask);
                m_neg[i] = run_en && ((t_win & t_mask) == 64'd0);
                m_hist[i] = t_win;
                m_ff[i]   = t_ff;
                if (t_match && xfer_duty_en) m_duty[i] = m_sduty[i];
                if (duty_wr[i]) m_sduty[i] = int'(duty_wdata);
            end
            m_irqp = t_match;
            m_cnt  = (!run_en || t_match) ? 0 : m_cnt + 1;
            if (t_match && xfer_prd_en) m_prd = m_sprd;
            if (prd_wr) m_sprd = int'(prd_wdata);
        end
    end

    // Compare every output against the model, away from the clock edge.
    logic [N_CH-1:0] e_pos, e_neg, e_irqd;
    always @(negedge clk) begin
        if (chk_on && !done) begin
            for (int i = 0; i < N_CH; i++) begin
                e_pos[i]  = m_pos[i] ^ pol_inv;
                e_neg[i]  = m_neg[i] ^ pol_inv;
                e_irqd[i] = m_irqd[i];
            end
            n_vec++;
            if (out_pos !== e_pos || out_neg !== e_neg ||
                irq_duty !== e_irqd || irq_prd !== m_irqp) begin
                n_bad++;
                $display("FAIL %s t=%0t pos=%b/%b neg=%b/%b irqd=%b/%b irqp=%b/%b (actual/expected)",
                         tag, $time, out_pos, e_pos, out_neg, e_neg,
                         irq_duty, e_irqd, irq_prd, m_irqp);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic wr_prd(input int v);
        prd_wr = 1'b1; prd_wdata = CNT_W'(v);
        wait_cyc(1);
        prd_wr = 1'b0;
    endtask

    task automatic wr_duty(input int ch, input int v);
        duty_wr = '0; duty_wr[ch] = 1'b1; duty_wdata = CNT_W'(v);
        wait_cyc(1);
        duty_wr = '0;
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired in %s", tag);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; run_en = 1'b0; prd_wr = 1'b0; prd_wdata = '0;
        duty_wr = '0; duty_wdata = '0; dt_val = '0;
        xfer_prd_en = 1'b0; xfer_duty_en = 1'b0; pol_inv = 1'b0;
        wait_cyc(1);
        chk_on = 1;
        tag = "R10 reset";
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // Basic sawtooth with mid, zero and full duty.
        tag = "R1 R5 R6 R8 basic sawtooth";
        xfer_prd_en = 1'b1; xfer_duty_en = 1'b1;
        wr_prd(9);
        wr_duty(0, 3); wr_duty(1, 0); wr_duty(2, 12);
        wait_cyc(3);
        run_en = 1'b1;
        wait_cyc(45);

        // Duty transfer blocked, period transfer allowed.
        tag = "R2 R3 duty transfer disabled";
        xfer_duty_en = 1'b0;
        wr_duty(0, 6); wr_duty(1, 9); wr_duty(2, 2);
        wr_prd(14);
        wait_cyc(40);

        // Period transfer blocked, duty transfer allowed.
        tag = "R3 period transfer disabled";
        xfer_duty_en = 1'b1; xfer_prd_en = 1'b0;
        wr_prd(4);
        wait_cyc(45);

        // Run enable dropped and restored.
        tag = "R4 run enable low";
        run_en = 1'b0;
        wait_cyc(12);
        run_en = 1'b1;
        wait_cyc(30);

        // Dead time longer than the narrowest pulse.
        tag = "R7 dead time";
        run_en = 1'b0;
        wait_cyc(3);
        dt_val = 8'd3;
        wait_cyc(10);
        run_en = 1'b1;
        wait_cyc(60);

        tag = "R9 polarity inverted";
        pol_inv = 1'b1;
        wait_cyc(30);
        pol_inv = 1'b0;

        // Short period with duty equal to period and duty zero.
        tag = "R6 full and zero duty";
        xfer_prd_en = 1'b1;
        wr_prd(1);
        wr_duty(0, 1); wr_duty(1, 0); wr_duty(2, 7);
        wait_cyc(40);

        tag = "R1 R8 long period";
        dt_val = 8'd0;
        run_en = 1'b0;
        wait_cyc(8);
        wr_prd(20);
        wr_duty(0, 5); wr_duty(1, 19); wr_duty(2, 20);
        run_en = 1'b1;
        wait_cyc(70);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule